// File: doc/BRIEF.md
# Debug Comparator Qualification Unit

This block sits between the address comparators of a processor's self-hosted debug logic and the exception machinery. The comparators report raw hits, one bit per breakpoint slot and one bit per watchpoint slot. The unit decides which of those hits become real debug events. It holds one control word for each slot and a context value for each breakpoint slot. It filters each hit by security state and by privilege level. A slot can also be chained to a context-aware breakpoint, and that breakpoint must then match the current context ID.

Software or a debug agent loads the control words through a narrow write port. Each cycle with `hitValid` high, the unit evaluates the hit vectors against the current exception level, security state and context ID. One clock later it reports, separately for breakpoints and watchpoints, whether any slot qualified and the index of the lowest slot that did. A watchpoint hit caused by an unprivileged load or store is judged as if it came from level 0.

Top module: `dbgq_top`

## Requirements
- R1: After reset both event outputs are 0, both index outputs are 0, and every control word and context value is 0, so a hit on any slot yields no event until that slot is configured.
- R2: A slot qualifies only if its hit bit is set with `hitValid` high and its enable bit (control bit 0) is 1. The result appears on `bpEvent`/`wpEvent` on the clock edge after the one that sampled the hit.
- R3: Security filter on control bits [15:14]: value 0 passes in both states; values 1 and 3 block when `isSecure` is 1; value 2 blocks when `isSecure` is 0.
- R4: Privilege filter: at level 2 or 3 the slot needs control bit 13 set; at level 1 it needs control bit 1; at level 0 it needs control bit 2.
- R5: For watchpoints only, `wpUnpriv` = 1 makes the privilege filter use level 0 whatever `curEl` holds. Breakpoint qualification ignores `wpUnpriv`.
- R6: No event of either kind is reported unless both `dbgEnable` and `dbgUnmasked` are 1 in the cycle of the hit.
- R7: When control bit 20 (link) is set, the breakpoint slot named by bits [19:16] must pass a link check. A slot number above NUM_BP-1, or below NUM_BP-NUM_CTX, always fails that check.
- R8: A link target passes only if its enable bit is 1, its type field (bits [23:20]) equals 3, and `contextId` equals its 32-bit context value. Every other type value, including 5, 9 and 11, fails.
- R9: A link check always fails when `curEl` is 2 or 3, even if `wpUnpriv` is set.
- R10: When several slots of one kind qualify, the lowest index is reported. Breakpoint and watchpoint results are independent. An index output is 0 whenever its event output is 0.
- R11: A write with `cfgWe` = 1 stores `cfgWdata` into slot `cfgIdx` of the space picked by `cfgSpace`: 0 is breakpoint control, 1 is breakpoint context value, 2 is watchpoint control. Space 3 and out-of-range indices change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSpace | input | 2 | Target array of the write |
| cfgIdx | input | 4 | Slot index of the write |
| cfgWdata | input | 32 | Write data |
| hitValid | input | 1 | Hit vectors and context inputs are valid this cycle |
| bpHit | input | NUM_BP | Raw breakpoint comparator hits |
| wpHit | input | NUM_WP | Raw watchpoint comparator hits |
| curEl | input | 2 | Current exception level 0..3 |
| isSecure | input | 1 | Current security state is secure |
| wpUnpriv | input | 1 | Data access came from an unprivileged load/store |
| contextId | input | 32 | Current context ID |
| dbgEnable | input | 1 | Global breakpoint/watchpoint enable |
| dbgUnmasked | input | 1 | Debug exceptions are currently allowed |
| bpEvent | output | 1 | A breakpoint qualified |
| bpIdx | output | log2(NUM_BP) | Lowest qualifying breakpoint slot |
| wpEvent | output | 1 | A watchpoint qualified |
| wpIdx | output | log2(NUM_WP) | Lowest qualifying watchpoint slot |

## Verification
The bench uses the defaults: 16 breakpoint slots, 16 watchpoint slots and 2 context-aware breakpoints. So the legal link targets are slots 14 and 15. That puts both edges of the link range in reach: slot 13 is refused and slot 14 is accepted, with identical target contents. Sixteen slots per kind also let the priority tests put hits at the top index 15 and at scattered lower ones together.

// File: rtl/dbgq_pkg.sv
package dbgq_pkg;

  localparam int WORD_W = 32;
  localparam int LBN_W  = 4;

  // Decoded filter fields of one slot control word
  typedef struct packed {
    logic             en;
    logic [1:0]       pac;
    logic             hmc;
    logic [1:0]       ssc;
    logic [LBN_W-1:0] lbn;
    logic             link;
  } slotCfg_t;

  // Control -> datapath strobes
  typedef struct packed {
    logic              wrBpCtrl;
    logic              wrBpVal;
    logic              wrWpCtrl;
    logic [LBN_W-1:0]  slot;
    logic [WORD_W-1:0] data;
    logic              evalEn;
    logic [1:0]        bpEl;
    logic [1:0]        wpEl;
  } ctlStrobe_t;

  function automatic slotCfg_t decodeCfg(input logic [WORD_W-1:0] w);
    slotCfg_t c;
    c.en   = w[0];
    c.pac  = w[2:1];
    c.hmc  = w[13];
    c.ssc  = w[15:14];
    c.lbn  = w[19:16];
    c.link = w[20];
    return c;
  endfunction

  function automatic logic sscPass(input logic [1:0] ssc, input logic sec);
    case (ssc)
      2'd0:    return 1'b1;
      2'd2:    return sec;
      default: return !sec;
    endcase
  endfunction

  function automatic logic elPass(input slotCfg_t c, input logic [1:0] el);
    case (el)
      2'd0:    return c.pac[1];
      2'd1:    return c.pac[0];
      default: return c.hmc;
    endcase
  endfunction

endpackage

// File: rtl/dbgq_ctrl.sv
module dbgq_ctrl
  import dbgq_pkg::*;
(
  input  logic              cfgWe,
  input  logic [1:0]        cfgSpace,
  input  logic [LBN_W-1:0]  cfgIdx,
  input  logic [WORD_W-1:0] cfgWdata,
  input  logic              hitValid,
  input  logic              dbgEnable,
  input  logic              dbgUnmasked,
  input  logic [1:0]        curEl,
  input  logic              wpUnpriv,
  output ctlStrobe_t        strobe
);

  always_comb begin
    strobe.wrBpCtrl = cfgWe && (cfgSpace == 2'd0);
    strobe.wrBpVal  = cfgWe && (cfgSpace == 2'd1);
    strobe.wrWpCtrl = cfgWe && (cfgSpace == 2'd2);
    strobe.slot     = cfgIdx;
    strobe.data     = cfgWdata;
    strobe.evalEn   = hitValid && dbgEnable && dbgUnmasked;
    strobe.bpEl     = curEl;
    strobe.wpEl     = wpUnpriv ? 2'd0 : curEl;
  end

endmodule

// File: rtl/dbgq_datapath.sv
module dbgq_datapath
  import dbgq_pkg::*;
#(
  parameter int NUM_BP  = 16,
  parameter int NUM_WP  = 16,
  parameter int NUM_CTX = 2,
  localparam int BP_IDX_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1,
  localparam int WP_IDX_W = (NUM_WP > 1) ? $clog2(NUM_WP) : 1,
  localparam int LINK_N   = 1 << LBN_W,
  localparam int CTX_LO   = NUM_BP - NUM_CTX
)(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [NUM_BP-1:0]   bpHit,
  input  logic [NUM_WP-1:0]   wpHit,
  input  logic                isSecure,
  input  logic [WORD_W-1:0]   contextId,
  output logic                bpEvent,
  output logic [BP_IDX_W-1:0] bpIdx,
  output logic                wpEvent,
  output logic [WP_IDX_W-1:0] wpIdx
);

  slotCfg_t          bpCfg  [NUM_BP];
  logic [3:0]        bpKind [NUM_BP];
  logic [WORD_W-1:0] bpVal  [NUM_BP];
  slotCfg_t          wpCfg  [NUM_WP];

  // Configuration storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BP; i++) begin
        bpCfg[i]  <= '0;
        bpKind[i] <= '0;
        bpVal[i]  <= '0;
      end
      for (int i = 0; i < NUM_WP; i++) wpCfg[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_BP; i++) begin
        if (strobe.wrBpCtrl && strobe.slot == LBN_W'(i)) begin
          bpCfg[i]  <= decodeCfg(strobe.data);
          bpKind[i] <= strobe.data[23:20];
        end
        if (strobe.wrBpVal && strobe.slot == LBN_W'(i))
          bpVal[i] <= strobe.data;
      end
      for (int i = 0; i < NUM_WP; i++)
        if (strobe.wrWpCtrl && strobe.slot == LBN_W'(i))
          wpCfg[i] <= decodeCfg(strobe.data);
    end
  end

  // Link check for every possible link number
  logic [LINK_N-1:0] linkPass;
  logic              ctxElOk;
  assign ctxElOk = (strobe.bpEl < 2'd2);

  for (genvar l = 0; l < LINK_N; l++) begin : g_link
    if (l < NUM_BP && l >= CTX_LO) begin : g_ctx
      assign linkPass[l] = bpCfg[l].en && (bpKind[l] == 4'd3) &&
                           ctxElOk && (contextId == bpVal[l]);
    end else begin : g_none
      assign linkPass[l] = 1'b0;
    end
  end

  // Per-slot qualification
  logic [NUM_BP-1:0] bpQual;
  logic [NUM_WP-1:0] wpQual;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    assign bpQual[i] = strobe.evalEn && bpHit[i] && bpCfg[i].en &&
                       sscPass(bpCfg[i].ssc, isSecure) &&
                       elPass(bpCfg[i], strobe.bpEl) &&
                       (!bpCfg[i].link || linkPass[bpCfg[i].lbn]);
  end

  for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
    assign wpQual[i] = strobe.evalEn && wpHit[i] && wpCfg[i].en &&
                       sscPass(wpCfg[i].ssc, isSecure) &&
                       elPass(wpCfg[i], strobe.wpEl) &&
                       (!wpCfg[i].link || linkPass[wpCfg[i].lbn]);
  end

  // Lowest-index selection
  logic [BP_IDX_W-1:0] bpSel;
  logic [WP_IDX_W-1:0] wpSel;

  always_comb begin
    bpSel = '0;
    for (int i = NUM_BP - 1; i >= 0; i--)
      if (bpQual[i]) bpSel = BP_IDX_W'(i);
  end

  always_comb begin
    wpSel = '0;
    for (int i = NUM_WP - 1; i >= 0; i--)
      if (wpQual[i]) wpSel = WP_IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpEvent <= 1'b0;
      bpIdx   <= '0;
      wpEvent <= 1'b0;
      wpIdx   <= '0;
    end else begin
      bpEvent <= |bpQual;
      bpIdx   <= bpSel;
      wpEvent <= |wpQual;
      wpIdx   <= wpSel;
    end
  end

endmodule

// File: rtl/dbgq_top.sv
module dbgq_top
  import dbgq_pkg::*;
#(
  parameter int NUM_BP  = 16,
  parameter int NUM_WP  = 16,
  parameter int NUM_CTX = 2,
  localparam int BP_IDX_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1,
  localparam int WP_IDX_W = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [1:0]          cfgSpace,
  input  logic [3:0]          cfgIdx,
  input  logic [31:0]         cfgWdata,
  input  logic                hitValid,
  input  logic [NUM_BP-1:0]   bpHit,
  input  logic [NUM_WP-1:0]   wpHit,
  input  logic [1:0]          curEl,
  input  logic                isSecure,
  input  logic                wpUnpriv,
  input  logic [31:0]         contextId,
  input  logic                dbgEnable,
  input  logic                dbgUnmasked,
  output logic                bpEvent,
  output logic [BP_IDX_W-1:0] bpIdx,
  output logic                wpEvent,
  output logic [WP_IDX_W-1:0] wpIdx
);

  ctlStrobe_t strobe;

  dbgq_ctrl i_ctrl (
    .cfgWe      (cfgWe),
    .cfgSpace   (cfgSpace),
    .cfgIdx     (cfgIdx),
    .cfgWdata   (cfgWdata),
    .hitValid   (hitValid),
    .dbgEnable  (dbgEnable),
    .dbgUnmasked(dbgUnmasked),
    .curEl      (curEl),
    .wpUnpriv   (wpUnpriv),
    .strobe     (strobe)
  );

  dbgq_datapath #(
    .NUM_BP (NUM_BP),
    .NUM_WP (NUM_WP),
    .NUM_CTX(NUM_CTX)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .bpHit    (bpHit),
    .wpHit    (wpHit),
    .isSecure (isSecure),
    .contextId(contextId),
    .bpEvent  (bpEvent),
    .bpIdx    (bpIdx),
    .wpEvent  (wpEvent),
    .wpIdx    (wpIdx)
  );

endmodule

// File: rtl/dbgq_checker.sv
module dbgq_checker #(
  parameter int NUM_BP = 16,
  parameter int NUM_WP = 16,
  parameter int BP_IDX_W = 4,
  parameter int WP_IDX_W = 4
)(
  input logic                clk,
  input logic                rstN,
  input logic                hitValid,
  input logic                dbgEnable,
  input logic                dbgUnmasked,
  input logic [NUM_BP-1:0]   bpHit,
  input logic [NUM_WP-1:0]   wpHit,
  input logic                bpEvent,
  input logic [BP_IDX_W-1:0] bpIdx,
  input logic                wpEvent,
  input logic [WP_IDX_W-1:0] wpIdx
);

  logic [NUM_BP-1:0] bpHitQ;
  logic [NUM_WP-1:0] wpHitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpHitQ <= '0;
      wpHitQ <= '0;
    end else begin
      bpHitQ <= bpHit;
      wpHitQ <= wpHit;
    end
  end

  // R6: an event needs both gates and a valid hit one cycle earlier
  assert_gate_open_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(hitValid && dbgEnable && dbgUnmasked) |=> !bpEvent && !wpEvent);

  // R2: the reported slot had its raw hit bit set
  assert_bp_idx_hit_R2: assert property (@(posedge clk) disable iff (!rstN)
    bpEvent |-> bpHitQ[bpIdx]);

  assert_wp_idx_hit_R2: assert property (@(posedge clk) disable iff (!rstN)
    wpEvent |-> wpHitQ[wpIdx]);

  // R10: index is zero when nothing qualified
  assert_bp_idx_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !bpEvent |-> bpIdx == '0);

  assert_wp_idx_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !wpEvent |-> wpIdx == '0);

endmodule

bind dbgq_top dbgq_checker #(
  .NUM_BP  (NUM_BP),
  .NUM_WP  (NUM_WP),
  .BP_IDX_W(BP_IDX_W),
  .WP_IDX_W(WP_IDX_W)
) i_dbgq_checker (
  .clk        (clk),
  .rstN       (rstN),
  .hitValid   (hitValid),
  .dbgEnable  (dbgEnable),
  .dbgUnmasked(dbgUnmasked),
  .bpHit      (bpHit),
  .wpHit      (wpHit),
  .bpEvent    (bpEvent),
  .bpIdx      (bpIdx),
  .wpEvent    (wpEvent),
  .wpIdx      (wpIdx)
);

// File: tb/test_dbgq_top.sv
module test_dbgq_top;

  localparam int NB = 16;
  localparam int NW = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSpace = '0;
  logic [3:0]  cfgIdx = '0;
  logic [31:0] cfgWdata = '0;
  logic        hitValid = 1'b0;
  logic [NB-1:0] bpHit = '0;
  logic [NW-1:0] wpHit = '0;
  logic [1:0]  curEl = '0;
  logic        isSecure = 1'b0;
  logic        wpUnpriv = 1'b0;
  logic [31:0] contextId = '0;
  logic        dbgEnable = 1'b1;
  logic        dbgUnmasked = 1'b1;
  logic        bpEvent, wpEvent;
  logic [3:0]  bpIdx, wpIdx;

  int vectors = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dbgq_top i_dbgq_top (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSpace(cfgSpace), .cfgIdx(cfgIdx),
    .cfgWdata(cfgWdata), .hitValid(hitValid), .bpHit(bpHit), .wpHit(wpHit),
    .curEl(curEl), .isSecure(isSecure), .wpUnpriv(wpUnpriv), .contextId(contextId),
    .dbgEnable(dbgEnable), .dbgUnmasked(dbgUnmasked), .bpEvent(bpEvent),
    .bpIdx(bpIdx), .wpEvent(wpEvent), .wpIdx(wpIdx)
  );

  function automatic logic [31:0] mk(input logic en, input logic [1:0] pac,
                                     input logic hmc, input logic [1:0] ssc,
                                     input logic [3:0] lbn, input logic lnk);
    return 32'(en) | (32'(pac) << 1) | (32'(hmc) << 13) | (32'(ssc) << 14) |
           (32'(lbn) << 16) | (32'(lnk) << 20);
  endfunction

  function automatic logic [31:0] mkCtx(input logic en, input logic [3:0] kind);
    return 32'(en) | (32'(kind) << 20);
  endfunction

  task automatic cfgWrite(input logic [1:0] sp, input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgSpace = sp; cfgIdx = idx; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Apply one hit cycle, then sample the registered result one edge later
  task automatic hitCheck(input string tag, input logic [NB-1:0] bh, input logic [NW-1:0] wh,
                          input logic [1:0] el, input logic sec, input logic unp,
                          input logic [31:0] ctx,
                          input logic expBp, input logic [3:0] expBpIdx,
                          input logic expWp, input logic [3:0] expWpIdx);
    @(negedge clk);
    hitValid = 1'b1; bpHit = bh; wpHit = wh; curEl = el; isSecure = sec;
    wpUnpriv = unp; contextId = ctx;
    @(negedge clk);
    hitValid = 1'b0; bpHit = '0; wpHit = '0;
    vectors++;
    if ({bpEvent, bpIdx, wpEvent, wpIdx} !== {expBp, expBpIdx, expWp, expWpIdx}) begin
      fails++;
      $display("FAIL %s: bp=%0b/%0d wp=%0b/%0d expected bp=%0b/%0d wp=%0b/%0d",
               tag, bpEvent, bpIdx, wpEvent, wpIdx, expBp, expBpIdx, expWp, expWpIdx);
    end
  endtask

  task automatic testReset();
    vectors++;
    if ({bpEvent, bpIdx, wpEvent, wpIdx} !== '0) begin
      fails++;
      $display("FAIL R1 reset outputs: %0b/%0d %0b/%0d expected 0/0 0/0",
               bpEvent, bpIdx, wpEvent, wpIdx);
    end
    hitCheck("R1 unconfigured slots", '1, '1, 2'd1, 1'b0, 1'b0, 0, 0, 0, 0, 0);
  endtask

  task automatic testBasic();
    cfgWrite(2'd0, 4'd3, mk(1, 2'b11, 0, 2'd0, 0, 0));
    cfgWrite(2'd0, 4'd4, mk(0, 2'b11, 1, 2'd0, 0, 0));
    hitCheck("R2 enabled bp slot 3", 16'h0008, '0, 2'd1, 0, 0, 0, 1, 3, 0, 0);
    hitCheck("R2 disabled bp slot 4", 16'h0010, '0, 2'd1, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic testSecurity();
    cfgWrite(2'd2, 4'd5, mk(1, 2'b11, 0, 2'd1, 0, 0));
    hitCheck("R3 ssc1 secure", '0, 16'h0020, 2'd1, 1, 0, 0, 0, 0, 0, 0);
    hitCheck("R3 ssc1 nonsecure", '0, 16'h0020, 2'd1, 0, 0, 0, 0, 0, 1, 5);
    cfgWrite(2'd2, 4'd5, mk(1, 2'b11, 0, 2'd2, 0, 0));
    hitCheck("R3 ssc2 secure", '0, 16'h0020, 2'd1, 1, 0, 0, 0, 0, 1, 5);
    hitCheck("R3 ssc2 nonsecure", '0, 16'h0020, 2'd1, 0, 0, 0, 0, 0, 0, 0);
    cfgWrite(2'd2, 4'd5, mk(1, 2'b11, 0, 2'd3, 0, 0));
    hitCheck("R3 ssc3 secure", '0, 16'h0020, 2'd1, 1, 0, 0, 0, 0, 0, 0);
    hitCheck("R3 ssc3 nonsecure", '0, 16'h0020, 2'd1, 0, 0, 0, 0, 0, 1, 5);
  endtask

  task automatic testPrivilege();
    cfgWrite(2'd0, 4'd7, mk(1, 2'b01, 0, 2'd0, 0, 0));
    hitCheck("R4 pac01 at EL1", 16'h0080, '0, 2'd1, 0, 0, 0, 1, 7, 0, 0);
    hitCheck("R4 pac01 at EL0", 16'h0080, '0, 2'd0, 0, 0, 0, 0, 0, 0, 0);
    hitCheck("R4 pac01 at EL2", 16'h0080, '0, 2'd2, 0, 0, 0, 0, 0, 0, 0);
    cfgWrite(2'd0, 4'd7, mk(1, 2'b10, 0, 2'd0, 0, 0));
    hitCheck("R4 pac10 at EL0", 16'h0080, '0, 2'd0, 0, 0, 0, 1, 7, 0, 0);
    hitCheck("R4 pac10 at EL1", 16'h0080, '0, 2'd1, 0, 0, 0, 0, 0, 0, 0);
    cfgWrite(2'd0, 4'd7, mk(1, 2'b00, 1, 2'd0, 0, 0));
    hitCheck("R4 hmc at EL3", 16'h0080, '0, 2'd3, 1, 0, 0, 1, 7, 0, 0);
    hitCheck("R4 hmc at EL1", 16'h0080, '0, 2'd1, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic testUnpriv();
    cfgWrite(2'd2, 4'd2, mk(1, 2'b10, 0, 2'd0, 0, 0));
    cfgWrite(2'd0, 4'd2, mk(1, 2'b10, 0, 2'd0, 0, 0));
    hitCheck("R5 wp EL1 privileged", '0, 16'h0004, 2'd1, 0, 0, 0, 0, 0, 0, 0);
    hitCheck("R5 wp EL1 unprivileged", '0, 16'h0004, 2'd1, 0, 1, 0, 0, 0, 1, 2);
    hitCheck("R5 bp ignores unpriv", 16'h0004, '0, 2'd1, 0, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic testGates();
    dbgEnable = 1'b0;
    hitCheck("R6 global enable off", 16'h0008, 16'h0004, 2'd0, 0, 1, 0, 0, 0, 0, 0);
    dbgEnable = 1'b1; dbgUnmasked = 1'b0;
    hitCheck("R6 exceptions masked", 16'h0008, 16'h0004, 2'd0, 0, 1, 0, 0, 0, 0, 0);
    dbgUnmasked = 1'b1;
    hitCheck("R6 both open", 16'h0008, 16'h0004, 2'd1, 0, 1, 0, 1, 3, 1, 2);
  endtask

  task automatic testLink();
    cfgWrite(2'd0, 4'd15, mkCtx(1, 4'd3));
    cfgWrite(2'd1, 4'd15, 32'hCAFE0001);
    cfgWrite(2'd2, 4'd1, mk(1, 2'b11, 0, 2'd0, 4'd15, 1));
    hitCheck("R8 link ctx match", '0, 16'h0002, 2'd1, 0, 0, 32'hCAFE0001, 0, 0, 1, 1);
    hitCheck("R8 link ctx mismatch", '0, 16'h0002, 2'd1, 0, 0, 32'hCAFE0003, 0, 0, 0, 0);
    cfgWrite(2'd0, 4'd13, mkCtx(1, 4'd3));
    cfgWrite(2'd1, 4'd13, 32'hCAFE0001);
    cfgWrite(2'd0, 4'd14, mkCtx(1, 4'd3));
    cfgWrite(2'd1, 4'd14, 32'hCAFE0001);
    cfgWrite(2'd2, 4'd1, mk(1, 2'b11, 0, 2'd0, 4'd13, 1));
    hitCheck("R7 link below ctx range", '0, 16'h0002, 2'd1, 0, 0, 32'hCAFE0001, 0, 0, 0, 0);
    cfgWrite(2'd2, 4'd1, mk(1, 2'b11, 0, 2'd0, 4'd14, 1));
    hitCheck("R7 link lowest ctx slot", '0, 16'h0002, 2'd1, 0, 0, 32'hCAFE0001, 0, 0, 1, 1);
    cfgWrite(2'd2, 4'd1, mk(1, 2'b11, 1, 2'd0, 4'd15, 1));
    hitCheck("R9 link at EL2", '0, 16'h0002, 2'd2, 0, 0, 32'hCAFE0001, 0, 0, 0, 0);
    hitCheck("R9 link at EL2 unpriv", '0, 16'h0002, 2'd2, 0, 1, 32'hCAFE0001, 0, 0, 0, 0);
    cfgWrite(2'd2, 4'd1, mk(1, 2'b11, 1, 2'd0, 4'd15, 0));
    hitCheck("R9 unlinked at EL2", '0, 16'h0002, 2'd2, 0, 0, 32'hCAFE0001, 0, 0, 1, 1);
    cfgWrite(2'd2, 4'd1, mk(1, 2'b11, 0, 2'd0, 4'd15, 1));
    cfgWrite(2'd0, 4'd15, mkCtx(1, 4'd5));
    hitCheck("R8 link type 5", '0, 16'h0002, 2'd1, 0, 0, 32'hCAFE0001, 0, 0, 0, 0);
    cfgWrite(2'd0, 4'd15, mkCtx(0, 4'd3));
    hitCheck("R8 link target disabled", '0, 16'h0002, 2'd1, 0, 0, 32'hCAFE0001, 0, 0, 0, 0);
  endtask

  task automatic testPriority();
    cfgWrite(2'd2, 4'd3, mk(1, 2'b11, 0, 2'd0, 0, 0));
    cfgWrite(2'd2, 4'd7, mk(1, 2'b11, 0, 2'd0, 0, 0));
    cfgWrite(2'd2, 4'd9, mk(1, 2'b11, 0, 2'd0, 0, 0));
    cfgWrite(2'd0, 4'd12, mk(1, 2'b11, 0, 2'd0, 0, 0));
    cfgWrite(2'd2, 4'd15, mk(1, 2'b11, 0, 2'd0, 0, 0));
    hitCheck("R10 lowest of 3/7/9", 16'h1000, 16'h0288, 2'd1, 0, 0, 0, 1, 12, 1, 3);
    hitCheck("R10 top slot only", '0, 16'h8000, 2'd1, 0, 0, 0, 0, 0, 1, 15);
    hitCheck("R10 skip unconfigured", 16'h1011, 16'h8201, 2'd1, 0, 0, 0, 1, 12, 1, 9);
  endtask

  task automatic testCfgSpace();
    cfgWrite(2'd3, 4'd3, 32'h0000_0000);
    hitCheck("R11 space 3 ignored", 16'h0008, 16'h0008, 2'd1, 0, 0, 0, 1, 3, 1, 3);
    cfgWrite(2'd2, 4'd3, 32'h0000_0000);
    hitCheck("R11 wp space write", 16'h0008, 16'h0008, 2'd1, 0, 0, 0, 1, 3, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testSecurity();
    testPrivilege();
    testUnpriv();
    testGates();
    testLink();
    testPriority();
    testCfgSpace();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule